// File: doc/BRIEF.md
# Snap Frame Sequencer

This block chooses, one frame at a time, the image type that a capture pipeline produces next and whether that frame carries a snap flag in its header. A snap request comes from an active-low push-button pin or from a software write. The block registers a new frame descriptor each time the pipeline reports the end of a frame, so a request never changes the frame already in flight.

Two policies are available. In tag mode every frame uses the configured type, and the frame that follows a snap request carries the flag. In switch mode the configuration holds a video type and a separate still-image type. A snap request lets the current frame finish, then one still frame with the flag set is issued, and video frames resume right after it. The pin can be qualified so that only a press held longer than a set time counts. A button-status flag records pin presses and is cleared by a status read.

Top module: `snap_frame_sequencer`

## Requirements
- R1: After reset, frame_type is 0, frame_snap is 0 and btn_status is 0.
- R2: A snap request is a cycle with sw_snap_wr=1 and sw_snap_wdata=1, or a qualified pin press. A write with sw_snap_wdata=0 does nothing, and sw_snap_rdata always reads 0.
- R3: frame_type and frame_snap change only in the cycle after a frame_done pulse. A snap request between pulses leaves them unchanged.
- R4: With toggle_mode=0, each frame_done loads frame_type with all of cfg_type. frame_snap is 1 for exactly the one frame issued at the first frame_done after a request, and 0 for the frame after it.
- R5: With toggle_mode=1, a video frame has frame_type = {2'b00, cfg_type[2:0]} and frame_snap=0. cfg_type[2:0] is the video field.
- R6: With toggle_mode=1, the first frame_done after a request issues one still frame with frame_type = {cfg_type[4:3], 3'b000} and frame_snap=1. The next frame_done returns to the video type.
- R7: A request that arrives while a request is already pending, or while a snap frame is being produced, is dropped. At most one request is held.
- R8: btn_status becomes 1 in the cycle after a pin press is accepted. A status_rd pulse with no press in the same cycle clears it on the next cycle.
- R9: When status_rd and a pin press fall in the same cycle, btn_status stays 1.
- R10: With hold_chk_en=1, a pin low period counts only if the synchronized pin stays low for more than HOLD_CYCLES clock cycles. A low period of exactly HOLD_CYCLES cycles is dropped. HOLD_CYCLES = CLK_KHZ*HOLD_TENTHS_MS/10.
- R11: One low period of the pin yields at most one press, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_pin_n | input | 1 | Asynchronous active-low snap button |
| sw_snap_wr | input | 1 | Software write strobe for the snap bit |
| sw_snap_wdata | input | 1 | Data written to the snap bit |
| sw_snap_rdata | output | 1 | Read-back value of the snap bit (always 0) |
| toggle_mode | input | 1 | 0: tag policy, 1: switch policy |
| hold_chk_en | input | 1 | Enables press-duration qualification |
| cfg_type | input | TYPE_W | Configured type; [2:0] video field, [4:3] still field |
| frame_done | input | 1 | One-cycle end-of-frame pulse from the pipeline |
| status_rd | input | 1 | Read strobe of the button status |
| frame_type | output | TYPE_W | Image type of the frame being produced |
| frame_snap | output | 1 | Snap flag for the current frame header |
| btn_status | output | 1 | Button-pressed status, cleared by a read |

## Verification
Two collisions matter here. The first is a status read that lands in the same cycle as a fresh pin press. The bench counts synchronizer stages and raises status_rd exactly in the cycle when the press is accepted, then expects btn_status to remain 1. The second is a snap request that arrives while another request is pending or while a snap frame is in production. Here a scoreboard of expected frame descriptors must show exactly one flagged frame, followed by an unflagged one.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
   typedef enum logic {
      FRM_NORMAL = 1'b0,
      FRM_SNAP   = 1'b1
   } frame_kind_e;
endpackage

// File: rtl/sfs_pin_qual.sv
module sfs_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 325000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic hold_en,
   output logic press
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 2);

   logic sq [SYNC_STAGES];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] thr;
   logic pin_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq[0] <= 1'b1;
      else        sq[0] <= pin_n;
   end

   for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq[g] <= 1'b1;
         else        sq[g] <= sq[g-1];
      end
   end

   assign pin_low = ~sq[SYNC_STAGES-1];
   assign thr     = hold_en ? CNT_W'(HOLD_CYCLES) : '0;

   // counts low cycles, stops one past the threshold so a period fires once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!pin_low)   cnt <= '0;
      else if (cnt <= thr) cnt <= cnt + CNT_W'(1);
   end

   assign press = pin_low && (cnt == thr);
endmodule

// File: rtl/sfs_status.sv
module sfs_status (
   input  logic clk,
   input  logic rst_n,
   input  logic press,
   input  logic rd,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (press) flag <= 1'b1;
      else if (rd)    flag <= 1'b0;
   end
endmodule

// File: rtl/sfs_frame_ctl.sv
module sfs_frame_ctl
   import sfs_pkg::*;
#(
   parameter int VID_W = 3,
   parameter int SNP_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frame_done,
   input  logic                   snap_req,
   input  logic                   toggled,
   input  logic [VID_W+SNP_W-1:0] cfg,
   output logic [VID_W+SNP_W-1:0] type_q,
   output logic                   snap_q,
   output logic                   pending
);
   localparam int TYPE_W = VID_W + SNP_W;

   frame_kind_e       kind_q;
   frame_kind_e       kind_n;
   logic              accept;
   logic [TYPE_W-1:0] type_n;

   assign accept = snap_req && !pending && (kind_q != FRM_SNAP);
   assign kind_n = pending ? FRM_SNAP : FRM_NORMAL;

   always_comb begin
      if (!toggled)              type_n = cfg;
      else if (kind_n == FRM_SNAP) type_n = {cfg[TYPE_W-1:VID_W], {VID_W{1'b0}}};
      else                       type_n = {{SNP_W{1'b0}}, cfg[VID_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= FRM_NORMAL;
         type_q  <= '0;
         pending <= 1'b0;
      end else begin
         pending <= accept | (pending & ~frame_done);
         if (frame_done) begin
            kind_q <= kind_n;
            type_q <= type_n;
         end
      end
   end

   assign snap_q = (kind_q == FRM_SNAP);
endmodule

// File: rtl/snap_frame_sequencer.sv
module snap_frame_sequencer #(
   parameter int VID_W          = 3,
   parameter int SNP_W          = 2,
   parameter int SYNC_STAGES    = 2,
   parameter int CLK_KHZ        = 125000,
   parameter int HOLD_TENTHS_MS = 26,
   localparam int TYPE_W        = VID_W + SNP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_pin_n,
   input  logic              sw_snap_wr,
   input  logic              sw_snap_wdata,
   output logic              sw_snap_rdata,
   input  logic              toggle_mode,
   input  logic              hold_chk_en,
   input  logic [TYPE_W-1:0] cfg_type,
   input  logic              frame_done,
   input  logic              status_rd,
   output logic [TYPE_W-1:0] frame_type,
   output logic              frame_snap,
   output logic              btn_status
);
   localparam int HOLD_CYCLES = CLK_KHZ * HOLD_TENTHS_MS / 10;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("hold window must be at least one cycle");
   end
   if (VID_W < 1 || SNP_W < 1) begin : g_bad_width
      $error("type fields need at least one bit each");
   end

   logic pin_press;
   logic sw_req;
   logic pending;

   assign sw_req        = sw_snap_wr & sw_snap_wdata;
   assign sw_snap_rdata = 1'b0;

   sfs_pin_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (snap_pin_n),
      .hold_en (hold_chk_en),
      .press   (pin_press)
   );

   sfs_status u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .press (pin_press),
      .rd    (status_rd),
      .flag  (btn_status)
   );

   sfs_frame_ctl #(
      .VID_W (VID_W),
      .SNP_W (SNP_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .snap_req   (sw_req | pin_press),
      .toggled    (toggle_mode),
      .cfg        (cfg_type),
      .type_q     (frame_type),
      .snap_q     (frame_snap),
      .pending    (pending)
   );
endmodule

// File: rtl/snap_frame_sequencer_chk.sv
module snap_frame_sequencer_chk #(
   parameter int VID_W  = 3,
   parameter int TYPE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_done,
   input logic              frame_snap,
   input logic [TYPE_W-1:0] frame_type,
   input logic              btn_status,
   input logic              status_rd,
   input logic              press,
   input logic              pending,
   input logic              toggle_mode,
   input logic [TYPE_W-1:0] cfg_type
);
   // R3
   hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> ($stable(frame_type) && $stable(frame_snap)));

   // R4
   tag_type_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !toggle_mode) |=> (frame_type == $past(cfg_type)));

   // R6
   one_snap_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_snap) |=> !frame_snap);

   // R6
   still_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && toggle_mode && pending) |=>
         (frame_snap && frame_type == {$past(cfg_type[TYPE_W-1:VID_W]), {VID_W{1'b0}}}));

   // R7
   pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !frame_done) |=> pending);

   // R8
   status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      press |=> btn_status);

   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !press) |=> !btn_status);
endmodule

bind snap_frame_sequencer snap_frame_sequencer_chk #(
   .VID_W  (VID_W),
   .TYPE_W (TYPE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_done  (frame_done),
   .frame_snap  (frame_snap),
   .frame_type  (frame_type),
   .btn_status  (btn_status),
   .status_rd   (status_rd),
   .press       (pin_press),
   .pending     (pending),
   .toggle_mode (toggle_mode),
   .cfg_type    (cfg_type)
);

// File: tb/snap_frame_sequencer_tb.sv
module snap_frame_sequencer_tb;
   localparam int CLK_KHZ = 10;
   localparam int HOLD_T  = 26;
   localparam int HOLD    = CLK_KHZ * HOLD_T / 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       snap_pin_n = 1'b1;
   logic       sw_snap_wr = 1'b0;
   logic       sw_snap_wdata = 1'b0;
   logic       sw_snap_rdata;
   logic       toggle_mode = 1'b0;
   logic       hold_chk_en = 1'b0;
   logic [4:0] cfg_type = '0;
   logic       frame_done = 1'b0;
   logic       status_rd = 1'b0;
   logic [4:0] frame_type;
   logic       frame_snap;
   logic       btn_status;

   snap_frame_sequencer #(
      .CLK_KHZ        (CLK_KHZ),
      .HOLD_TENTHS_MS (HOLD_T)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .snap_pin_n    (snap_pin_n),
      .sw_snap_wr    (sw_snap_wr),
      .sw_snap_wdata (sw_snap_wdata),
      .sw_snap_rdata (sw_snap_rdata),
      .toggle_mode   (toggle_mode),
      .hold_chk_en   (hold_chk_en),
      .cfg_type      (cfg_type),
      .frame_done    (frame_done),
      .status_rd     (status_rd),
      .frame_type    (frame_type),
      .frame_snap    (frame_snap),
      .btn_status    (btn_status)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   typedef struct {
      logic [4:0] t;
      logic       s;
      string      req;
   } exp_t;

   exp_t sb_q[$];
   event mon_ev;

   // monitor: compare descriptors once they have been registered
   initial begin
      forever begin
         @(mon_ev);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.req, " type"}, 32'(frame_type), 32'(e.t));
            chk({e.req, " snap"}, 32'(frame_snap), 32'(e.s));
         end
      end
   end

   task automatic frame(input logic [4:0] t, input logic s, input string req);
      exp_t e;
      @(negedge clk) frame_done = 1'b1;
      @(negedge clk) frame_done = 1'b0;
      e.t = t; e.s = s; e.req = req;
      sb_q.push_back(e);
      ->mon_ev;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sw_snap(input logic d);
      @(negedge clk) begin sw_snap_wr = 1'b1; sw_snap_wdata = d; end
      @(negedge clk) begin sw_snap_wr = 1'b0; sw_snap_wdata = 1'b0; end
   endtask

   task automatic pin_pulse(input int n);
      @(negedge clk) snap_pin_n = 1'b0;
      repeat (n) @(negedge clk);
      snap_pin_n = 1'b1;
   endtask

   task automatic rd_status();
      @(negedge clk) status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 type", 32'(frame_type), 0);
      chk("R1 snap", 32'(frame_snap), 0);
      chk("R1 status", 32'(btn_status), 0);

      // tag policy
      cfg_type = 5'h1A;
      frame(5'h1A, 1'b0, "R4 plain");
      sw_snap(1'b0);
      idle(3);
      chk("R2 readback", 32'(sw_snap_rdata), 0);
      frame(5'h1A, 1'b0, "R2 zero write");
      sw_snap(1'b1);
      chk("R2 readback after 1", 32'(sw_snap_rdata), 0);
      idle(3);
      chk("R3 no change before frame_done", 32'(frame_snap), 0);
      frame(5'h1A, 1'b1, "R4 tagged");
      frame(5'h1A, 1'b0, "R4 untagged after");

      // pin press, no qualification
      pin_pulse(3);
      idle(5);
      chk("R8 status set", 32'(btn_status), 1);
      frame(5'h1A, 1'b1, "R2 pin request");
      frame(5'h1A, 1'b0, "R2 pin request after");
      rd_status();
      chk("R8 status cleared", 32'(btn_status), 0);

      // read and press in the same cycle
      @(negedge clk) snap_pin_n = 1'b0;
      @(negedge clk);
      @(negedge clk) status_rd = 1'b1;
      @(negedge clk) status_rd = 1'b0;
      chk("R9 status kept", 32'(btn_status), 1);
      idle(3);
      snap_pin_n = 1'b1;
      frame(5'h1A, 1'b1, "R9 press consumed");
      frame(5'h1A, 1'b0, "R9 after");
      rd_status();

      // dropped requests
      sw_snap(1'b1);
      idle(2);
      sw_snap(1'b1);
      idle(2);
      frame(5'h1A, 1'b1, "R7 pending");
      frame(5'h1A, 1'b0, "R7 second dropped");
      sw_snap(1'b1);
      frame(5'h1A, 1'b1, "R7 snap frame");
      sw_snap(1'b1);
      frame(5'h1A, 1'b0, "R7 in-progress dropped");
      frame(5'h1A, 1'b0, "R7 still clear");

      // switch policy
      toggle_mode = 1'b1;
      cfg_type = 5'b01011;
      frame(5'b00011, 1'b0, "R5 video");
      sw_snap(1'b1);
      frame(5'b01000, 1'b1, "R6 still");
      frame(5'b00011, 1'b0, "R6 resume");
      cfg_type = 5'b11011;
      pin_pulse(3);
      idle(5);
      frame(5'b11000, 1'b1, "R6 still from pin");
      frame(5'b00011, 1'b0, "R5 video again");

      // hold qualification
      hold_chk_en = 1'b1;
      rd_status();
      pin_pulse(HOLD);
      idle(5);
      chk("R10 short press dropped", 32'(btn_status), 0);
      frame(5'b00011, 1'b0, "R10 no request");
      pin_pulse(HOLD + 1);
      idle(5);
      chk("R10 long press", 32'(btn_status), 1);
      frame(5'b11000, 1'b1, "R10 still");
      frame(5'b00011, 1'b0, "R10 resume");

      // one press per low period
      rd_status();
      @(negedge clk) snap_pin_n = 1'b0;
      idle(HOLD + 10);
      rd_status();
      idle(20);
      chk("R11 single press", 32'(btn_status), 0);
      snap_pin_n = 1'b1;
      idle(5);
      frame(5'b11000, 1'b1, "R11 still");
      frame(5'b00011, 1'b0, "R11 resume");

      idle(2);
      finish_run();
   end
endmodule